// File: doc/BRIEF.md
# Two-Half Interrupt Request Controller

This block collects interrupt requests from 32 peripheral sources and presents them to a processor. Each source line is pulsed high for a cycle to latch its request flag. Software reaches a 32-bit enable mask and a 32-bit request register as two 16-bit halves each, plus a one-bit master enable. A request is cleared by writing a one to its flag bit.

The controller drives two signals toward the CPU. The wake output pulses when a newly raised source is enabled, whether or not the master enable is on, so a halted core can resume. The interrupt path re-evaluates enabled and pending requests on certain events. When the master enable is set, it captures the enabled pending set into a latch. The latch is handed to the CPU as a single-cycle `irq_o` pulse with the captured bits, but only while the CPU's interrupt-disable input is low. Until then it is held.

Top module: `irqc_top`

## Requirements
- R1: A one-cycle pulse on `src_i[n]` sets request bit n. Sources 0 to 15 appear in the low request half (select 2) at bit n, and sources 16 to 31 appear in the high request half (select 3) at bit n-16.
- R2: `wake_o` is high for the one cycle after the clock edge at which a source was raised whose enable bit is set, even when the master enable is 0.
- R3: While the master enable is 0, no interrupt is captured and `irq_o` stays low, even if enabled requests are pending.
- R4: The enabled pending set (enable AND request, all 32 bits) is evaluated on three events: a raised source that is enabled, any write to an enable half, and a nonzero write to the master enable. If the master enable is 1 and the set is nonzero, it is captured into the pending latch at that edge.
- R5: When the latch is nonzero and `cpu_irq_off_i` is low at a clock edge, `irq_o` is high for the following cycle with `irq_bits_o` equal to the latch, and the latch clears. While `cpu_irq_off_i` is high, the latch is held and `irq_o` stays low.
- R6: Writing a one to a request bit clears it, and writing a zero leaves it unchanged. If a source raises a bit in the same cycle that a write clears it, the bit stays set.
- R7: Reads return current values. The selects are 0 for the enable low half, 1 for the enable high half, 2 for the request low half, 3 for the request high half and 4 for the master enable. Only bit 0 of the master enable is stored, and its read has bits 15:1 at zero.
- R8: After reset, all registers and the pending latch are zero, and `wake_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Source request pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for writes |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Register select for reads |
| rd_data_o | output | 16 | Read data (combinational) |
| cpu_irq_off_i | input | 1 | CPU interrupt-disable flag |
| wake_o | output | 1 | Release-from-halt pulse |
| irq_o | output | 1 | Interrupt delivery pulse |
| irq_bits_o | output | 32 | Pending mask delivered with `irq_o` |

## Verification
The assertions assume two things about the inputs. Source lines are pulses that are sampled at clock edges, and the interrupt-disable flag is a level that changes only between edges. The stimulus drives every input at the falling edge and returns each source line to zero after one cycle. It never issues a request-clear write in the same cycle as an event whose captured value it predicts, except in the deliberate set-versus-clear case. Expected deliveries go into a queue before the event that causes them, so each `irq_o` pulse is matched against the bits predicted from the enable and request state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int HALF_W   = 16;
    localparam int NUM_HALF = 2;
    localparam int NUM_SRC  = HALF_W * NUM_HALF;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_EN_LO  = 3'd0,
        SEL_EN_HI  = 3'd1,
        SEL_REQ_LO = 3'd2,
        SEL_REQ_HI = 3'd3,
        SEL_MASTER = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        reg_sel_e          sel;
        logic [HALF_W-1:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] en_nx;
        logic [NUM_SRC-1:0] req_nx;
        logic               master_nx;
        logic               en_written;
        logic               master_set;
    } eval_in_t;

    function automatic reg_sel_e en_sel(input int h);
        return (h == 0) ? SEL_EN_LO : SEL_EN_HI;
    endfunction

    function automatic reg_sel_e req_sel(input int h);
        return (h == 0) ? SEL_REQ_LO : SEL_REQ_HI;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            wr,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] req_q,
    output logic               master_q,
    output eval_in_t           ev
);
    logic [NUM_HALF-1:0] en_hit;
    logic [NUM_HALF-1:0] req_hit;
    logic [NUM_SRC-1:0]  en_nx;
    logic [NUM_SRC-1:0]  req_nx;
    logic                master_hit;
    logic                master_nx;

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        localparam int LO = h * HALF_W;
        logic [HALF_W-1:0] clr_mask;

        assign en_hit[h]  = wr.we && (wr.sel == en_sel(h));
        assign req_hit[h] = wr.we && (wr.sel == req_sel(h));
        assign clr_mask   = req_hit[h] ? wr.data : '0;

        always_comb begin
            en_nx[LO +: HALF_W]  = en_hit[h] ? wr.data : en_q[LO +: HALF_W];
            req_nx[LO +: HALF_W] = (req_q[LO +: HALF_W] & ~clr_mask)
                                 | src[LO +: HALF_W];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[LO +: HALF_W]  <= '0;
                req_q[LO +: HALF_W] <= '0;
            end else begin
                en_q[LO +: HALF_W]  <= en_nx[LO +: HALF_W];
                req_q[LO +: HALF_W] <= req_nx[LO +: HALF_W];
            end
        end
    end

    assign master_hit = wr.we && (wr.sel == SEL_MASTER);
    assign master_nx  = master_hit ? wr.data[0] : master_q;

    always_ff @(posedge clk) begin
        if (rst) master_q <= 1'b0;
        else     master_q <= master_nx;
    end

    always_comb begin
        ev.en_nx      = en_nx;
        ev.req_nx     = req_nx;
        ev.master_nx  = master_nx;
        ev.en_written = |en_hit;
        ev.master_set = master_hit && (wr.data != '0);
    end
endmodule

// File: rtl/irqc_eval.sv
module irqc_eval
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    input  eval_in_t           ev,
    input  logic               cpu_irq_off,
    output logic               wake,
    output logic               irq,
    output logic [NUM_SRC-1:0] irq_bits,
    output logic               pend_any
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] capture;
    logic [NUM_SRC-1:0] pend_base;
    logic               src_enabled;
    logic               trigger;
    logic               deliver;

    assign src_enabled = |(src & ev.en_nx);
    assign trigger     = src_enabled || ev.en_written || ev.master_set;
    assign capture     = (trigger && ev.master_nx) ? (ev.en_nx & ev.req_nx) : '0;
    assign deliver     = (pend_q != '0) && !cpu_irq_off;
    assign pend_base   = deliver ? '0 : pend_q;
    assign pend_any    = (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            irq      <= 1'b0;
            irq_bits <= '0;
            wake     <= 1'b0;
        end else begin
            pend_q   <= pend_base | capture;
            irq      <= deliver;
            irq_bits <= deliver ? pend_q : '0;
            wake     <= src_enabled;
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        src_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [15:0]        wr_data_i,
    input  logic [2:0]         rd_sel_i,
    output logic [15:0]        rd_data_o,
    input  logic               cpu_irq_off_i,
    output logic               wake_o,
    output logic               irq_o,
    output logic [31:0]        irq_bits_o
);
    reg_wr_t            wr;
    eval_in_t           ev;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] req_q;
    logic               master_q;
    logic               pend_any;

    always_comb begin
        wr.we   = wr_en_i;
        wr.sel  = reg_sel_e'(wr_sel_i);
        wr.data = wr_data_i;
    end

    irqc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .src      (src_i),
        .en_q     (en_q),
        .req_q    (req_q),
        .master_q (master_q),
        .ev       (ev)
    );

    irqc_eval u_eval (
        .clk         (clk),
        .rst         (rst),
        .src         (src_i),
        .ev          (ev),
        .cpu_irq_off (cpu_irq_off_i),
        .wake        (wake_o),
        .irq         (irq_o),
        .irq_bits    (irq_bits_o),
        .pend_any    (pend_any)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel_i))
            SEL_EN_LO:  rd_data_o = en_q[HALF_W-1:0];
            SEL_EN_HI:  rd_data_o = en_q[NUM_SRC-1:HALF_W];
            SEL_REQ_LO: rd_data_o = req_q[HALF_W-1:0];
            SEL_REQ_HI: rd_data_o = req_q[NUM_SRC-1:HALF_W];
            SEL_MASTER: rd_data_o = {{(HALF_W-1){1'b0}}, master_q};
            default:    rd_data_o = '0;
        endcase
    end
endmodule

module irqc_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [31:0]        src_i,
    input logic [2:0]         rd_sel_i,
    input logic [15:0]        rd_data_o,
    input logic               cpu_irq_off_i,
    input logic               wake_o,
    input logic               irq_o,
    input logic [31:0]        irq_bits_o,
    input logic [NUM_SRC-1:0] req_q,
    input logic               master_q,
    input logic               pend_any
);
    // R1
    a_r1_src_sets: assert property (@(posedge clk) disable iff (rst)
        (src_i != '0) |=> ((req_q & $past(src_i)) == $past(src_i)));
    // R2
    a_r2_wake_cause: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(src_i) != '0));
    // R3
    a_r3_capture_gated: assert property (@(posedge clk) disable iff (rst)
        (pend_any && !$past(pend_any)) |-> master_q);
    // R5
    a_r5_hold_masked: assert property (@(posedge clk) disable iff (rst)
        cpu_irq_off_i |=> !irq_o);
    // R5
    a_r5_bits_present: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (irq_bits_o != '0));
    // R7
    a_r7_master_width: assert property (@(posedge clk) disable iff (rst)
        (rd_sel_i == SEL_MASTER) |-> (rd_data_o[15:1] == '0));
endmodule

bind irqc_top irqc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .src_i         (src_i),
    .rd_sel_i      (rd_sel_i),
    .rd_data_o     (rd_data_o),
    .cpu_irq_off_i (cpu_irq_off_i),
    .wake_o        (wake_o),
    .irq_o         (irq_o),
    .irq_bits_o    (irq_bits_o),
    .req_q         (req_q),
    .master_q      (master_q),
    .pend_any      (pend_any)
);

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_sel_i = '0;
    logic [15:0] rd_data_o;
    logic        cpu_irq_off_i = 1'b0;
    logic        wake_o;
    logic        irq_o;
    logic [31:0] irq_bits_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    irqc_top u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [15:0] d);
        @(negedge clk);
        rd_sel_i = sel;
        #1 d = rd_data_o;
    endtask

    task automatic pulse(input int n, output logic wk);
        @(negedge clk);
        src_i = 32'd1 << n;
        @(negedge clk);
        src_i = '0;
        wk = wake_o;
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, {31'd0, irq_o}, 32'd0);
        end
    endtask

    // scoreboard monitor: each irq pulse must match the oldest expected mask
    always @(negedge clk) begin
        if (!rst && irq_o) begin
            if (exp_q.size() == 0) check("R5 unexpected irq", irq_bits_o, 32'd0);
            else check("R5 irq bits", irq_bits_o, exp_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic wk;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), d);
            check("R8 reg reset", {16'd0, d}, 32'd0);
        end
        check("R8 irq low", {31'd0, irq_o}, 32'd0);
        check("R8 wake low", {31'd0, wake_o}, 32'd0);

        // R1 low-half source, not enabled: no wake
        pulse(3, wk);
        check("R2 no wake when disabled", {31'd0, wk}, 32'd0);
        rd(3'd2, d);
        check("R1 low half bit3", {16'd0, d}, 32'h0008);

        // R3 enable with master off: nothing captured
        wr(3'd0, 16'h0008);
        quiet("R3 no irq master off", 3);

        // R4 nonzero master write captures, R5 delivery
        exp_q.push_back(32'h0000_0008);
        wr(3'd4, 16'h0001);
        repeat (3) @(negedge clk);
        check("R5 queue drained", 32'(exp_q.size()), 32'd0);
        wr(3'd2, 16'h0008);
        rd(3'd2, d);
        check("R6 write-one clears", {16'd0, d}, 32'h0000);

        // R5 hold while CPU masks, R1 high half, R2 wake
        cpu_irq_off_i = 1'b1;
        wr(3'd1, 16'h0010);
        pulse(20, wk);
        check("R2 wake on enabled source", {31'd0, wk}, 32'd1);
        rd(3'd3, d);
        check("R1 high half bit4", {16'd0, d}, 32'h0010);
        quiet("R5 held while masked", 4);
        exp_q.push_back(32'h0010_0000);
        @(negedge clk);
        cpu_irq_off_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 released on unmask", 32'(exp_q.size()), 32'd0);
        wr(3'd3, 16'h0010);

        // R2 wake ignores master enable, R3 no irq
        wr(3'd4, 16'h0000);
        pulse(3, wk);
        check("R2 wake with master off", {31'd0, wk}, 32'd1);
        quiet("R3 no irq master off", 3);
        wr(3'd2, 16'h0008);

        // R6 write-zero and set-over-clear
        pulse(9, wk);
        wr(3'd2, 16'h0000);
        rd(3'd2, d);
        check("R6 write zero keeps", {16'd0, d}, 32'h0200);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'd2; wr_data_i = 16'h0200; src_i = 32'h0000_0200;
        @(negedge clk);
        wr_en_i = 1'b0; src_i = '0;
        rd(3'd2, d);
        check("R6 set wins over clear", {16'd0, d}, 32'h0200);
        wr(3'd2, 16'h0200);

        // R7 master stores bit0 only (no enabled request pending)
        wr(3'd4, 16'hFFFF);
        rd(3'd4, d);
        check("R7 master bit0 only", {16'd0, d}, 32'h0001);
        quiet("R4 empty set no capture", 2);

        // R4 enable write re-evaluates
        pulse(12, wk);
        exp_q.push_back(32'h0000_1000);
        wr(3'd0, 16'h1008);
        rd(3'd0, d);
        check("R7 enable readback", {16'd0, d}, 32'h1008);
        repeat (3) @(negedge clk);
        check("R4 enable write capture", 32'(exp_q.size()), 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule